// File: doc/BRIEF.md
# Program Counter and Subroutine Return Stack

This block owns the 16-bit fetch address of a small 4-bit processor core, the dedicated on-chip stack that holds return addresses, and the master interrupt enable bit. Once per accepted step it works out the next fetch address from an operation code supplied by the instruction decoder. The code can ask for a plain advance, a full 16-bit jump, a jump inside the current 4K-word page, a signed 8-bit relative jump, or a jump indexed by the 4-bit accumulator. It can also ask for a subroutine call, a return, an interrupt entry or an interrupt return.

The return stack is a separate 32-entry array of 16-bit words. It is addressed by a 5-bit pointer that software can read but not write. The pointer is shown as two nibble-wide special-function views. The interrupt enable bit has a nibble view of its own. A push with the pointer at its top value, or a pop with the pointer at zero, is refused and reported on an error output.

A small state machine governs returns. The stack array has a registered read port, so a return spends one extra cycle while the saved address comes out of the array. The states are:

- `S_RUN`: operations are accepted.
- `S_RET_LOAD`: the saved address is loaded into the PC.
- `S_RETI_LOAD`: the saved address is loaded into the PC and the enable bit is set.

The transitions are:

- `S_RUN` goes to `S_RET_LOAD` on an accepted return.
- `S_RUN` goes to `S_RETI_LOAD` on an accepted interrupt return.
- `S_RET_LOAD` and `S_RETI_LOAD` always go back to `S_RUN` on the next edge.
- Every other case stays in `S_RUN`.

Top module: `pc_callstack_unit`

## Requirements
- R1: After reset the PC is 0000H, the stack pointer is 0, the enable bit is 0, and `busy` and `stk_err` are 0.
- R2: With `step` low the PC and pointer hold. Op code 0 (advance) sets PC to PC+1. Codes 12 to 15 also act as advance. Every operation takes effect on the clock edge that samples `step` high.
- R3: Op code 1 (long jump) loads all 16 bits of `imm` into the PC.
- R4: Op code 2 (page jump) sets PC to {PC[15:12], imm[11:0]}.
- R5: Op code 3 (relative jump) sets PC to PC+1 plus `imm[7:0]` sign-extended. The sum wraps modulo 2^16.
- R6: Op code 4 (accumulator jump) sets PC to PC+1+`acc`, modulo 2^16.
- R7: Op code 5 (long call) and op code 6 (page call) write PC+1 to stack entry `sp` and increment `sp`. They load the PC with the target of op 1 or op 2 respectively.
- R8: Op code 7 (return) decrements `sp` and raises `busy` for one cycle. On the second edge it loads the PC from the entry just released. Entries come back last-in first-out.
- R9: Op code 9 (interrupt entry) saves the current PC, not PC+1, on the stack and increments `sp`. It loads PC with {8'h00, vec} and clears the enable bit.
- R10: Op code 8 (interrupt return) behaves like op 7 and also sets the enable bit to 1.
- R11: Op code 10 sets the enable bit and op code 11 clears it. Both advance the PC by one.
- R12: `sp_lo_sfr` is sp[3:0]. `sp_hi_sfr` is {3'b111, sp[4]}. `mie_sfr` is {3'b111, enable}.
- R13: A push (ops 5, 6, 9) with `sp`=31, or a pop (ops 7, 8) with `sp`=0, is dropped. PC, pointer and enable bit stay unchanged and no busy cycle follows. `stk_err` is high for the one cycle after that edge and low otherwise.
- R14: While `busy` is high, `step` and every operand input are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step | input | 1 | Carry out the operation on `op` at this edge |
| op | input | 4 | Operation code (see R2 to R11) |
| imm | input | 16 | Address field: full, page-low 12 bits, or relative offset in bits 7..0 |
| acc | input | 4 | Accumulator value for the indexed jump |
| vec | input | 8 | Interrupt entry address, low byte |
| pc | output | 16 | Current fetch address |
| sp_lo_sfr | output | 4 | Read view of pointer bits 3..0 |
| sp_hi_sfr | output | 4 | Read view of pointer bit 4 in bit 0, other bits 1 |
| mie_sfr | output | 4 | Read view of enable bit in bit 0, other bits 1 |
| busy | output | 1 | Return in progress; inputs are ignored |
| stk_err | output | 1 | Previous operation was refused for stack overflow or underflow |

## Verification
The checker assumes that `op` and `step` are settled well before each rising edge. It also assumes that reset is asserted before any operation, so that a past value never predates reset. The bench meets this by driving every input on the falling edge. It only ever lowers `step` once a step has been taken, which lets the hold property observe genuinely idle cycles. Random op codes span all sixteen values, including the unused ones. Directed sequences push the pointer to its top, pop it to zero and drive operations into the busy cycle, so that the overflow, underflow and ignore paths are reached and not only the ordinary jumps.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [3:0] {
        OP_SEQ   = 4'd0,
        OP_LJMP  = 4'd1,
        OP_PJMP  = 4'd2,
        OP_RJMP  = 4'd3,
        OP_AJMP  = 4'd4,
        OP_LCALL = 4'd5,
        OP_PCALL = 4'd6,
        OP_RET   = 4'd7,
        OP_RETI  = 4'd8,
        OP_INT   = 4'd9,
        OP_EI    = 4'd10,
        OP_DI    = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        S_RUN       = 2'd0,
        S_RET_LOAD  = 2'd1,
        S_RETI_LOAD = 2'd2
    } st_e;
endpackage

// File: rtl/pcs_target.sv
module pcs_target
    import pcs_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int PAGE_W = 12,
    parameter int REL_W  = 8,
    parameter int ACC_W  = 4,
    parameter int VEC_W  = 8
) (
    input  op_e              op,
    input  logic [PC_W-1:0]  pc,
    input  logic [PC_W-1:0]  imm,
    input  logic [ACC_W-1:0] acc,
    input  logic [VEC_W-1:0] vec,
    output logic [PC_W-1:0]  next_seq,
    output logic [PC_W-1:0]  tgt
);
    logic [PC_W-1:0] rel_ext, acc_ext, vec_ext, page_tgt;

    assign next_seq = pc + 1'b1;
    assign rel_ext  = {{(PC_W-REL_W){imm[REL_W-1]}}, imm[REL_W-1:0]};
    assign acc_ext  = {{(PC_W-ACC_W){1'b0}}, acc};
    assign vec_ext  = {{(PC_W-VEC_W){1'b0}}, vec};
    assign page_tgt = {pc[PC_W-1:PAGE_W], imm[PAGE_W-1:0]};

    always_comb begin
        case (op)
            OP_LJMP, OP_LCALL: tgt = imm;
            OP_PJMP, OP_PCALL: tgt = page_tgt;
            OP_RJMP:           tgt = next_seq + rel_ext;
            OP_AJMP:           tgt = next_seq + acc_ext;
            OP_INT:            tgt = vec_ext;
            default:           tgt = next_seq;
        endcase
    end
endmodule

// File: rtl/pcs_stack_ram.sv
module pcs_stack_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pc_callstack_unit.sv
module pc_callstack_unit
    import pcs_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int SP_W   = 5,
    parameter int NIB    = 4,
    parameter int PAGE_W = 12,
    parameter int REL_W  = 8,
    parameter int VEC_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [3:0]       op,
    input  logic [PC_W-1:0]  imm,
    input  logic [NIB-1:0]   acc,
    input  logic [VEC_W-1:0] vec,
    output logic [PC_W-1:0]  pc,
    output logic [NIB-1:0]   sp_lo_sfr,
    output logic [NIB-1:0]   sp_hi_sfr,
    output logic [NIB-1:0]   mie_sfr,
    output logic             busy,
    output logic             stk_err
);
    localparam int DEPTH = 1 << SP_W;
    localparam int HI_W  = SP_W - NIB;
    localparam logic [SP_W-1:0] SP_TOP = SP_W'(DEPTH - 1);

    st_e state, state_nx;
    op_e opc;
    logic [SP_W-1:0] sp;
    logic            mie;
    logic [PC_W-1:0] next_seq, tgt, push_data, rdata;
    logic            is_push, is_pop, go, bad, do_op;

    assign opc = op_e'(op);

    pcs_target #(.PC_W(PC_W), .PAGE_W(PAGE_W), .REL_W(REL_W),
                 .ACC_W(NIB), .VEC_W(VEC_W)) u_tgt (
        .op(opc), .pc(pc), .imm(imm), .acc(acc), .vec(vec),
        .next_seq(next_seq), .tgt(tgt)
    );

    assign is_push   = (opc == OP_LCALL) || (opc == OP_PCALL) || (opc == OP_INT);
    assign is_pop    = (opc == OP_RET) || (opc == OP_RETI);
    assign go        = step && (state == S_RUN);
    assign bad       = go && ((is_push && sp == SP_TOP) || (is_pop && sp == '0));
    assign do_op     = go && !bad;
    assign push_data = (opc == OP_INT) ? pc : next_seq;

    pcs_stack_ram #(.W(PC_W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(do_op && is_push), .waddr(sp), .wdata(push_data),
        .raddr(sp - 1'b1), .rdata(rdata)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_RUN: begin
                if (do_op && opc == OP_RET)       state_nx = S_RET_LOAD;
                else if (do_op && opc == OP_RETI) state_nx = S_RETI_LOAD;
            end
            S_RET_LOAD:  state_nx = S_RUN;
            S_RETI_LOAD: state_nx = S_RUN;
            default:     state_nx = S_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_RUN;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc      <= '0;
            sp      <= '0;
            mie     <= 1'b0;
            stk_err <= 1'b0;
        end else begin
            stk_err <= bad;
            unique case (state)
                S_RUN: begin
                    if (do_op) begin
                        if (is_pop) begin
                            sp <= sp - 1'b1;
                        end else begin
                            pc <= tgt;
                            if (is_push) sp <= sp + 1'b1;
                            if (opc == OP_INT || opc == OP_DI) mie <= 1'b0;
                            if (opc == OP_EI)                  mie <= 1'b1;
                        end
                    end
                end
                S_RET_LOAD: pc <= rdata;
                S_RETI_LOAD: begin
                    pc  <= rdata;
                    mie <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != S_RUN);
        sp_lo_sfr = sp[NIB-1:0];
        sp_hi_sfr = {{(NIB-HI_W){1'b1}}, sp[SP_W-1:NIB]};
        mie_sfr   = {{(NIB-1){1'b1}}, mie};
    end
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker
    import pcs_pkg::*;
#(
    parameter int PC_W = 16,
    parameter int NIB  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            step,
    input logic [3:0]      op,
    input logic [PC_W-1:0] pc,
    input logic [NIB-1:0]  sp_lo,
    input logic            sp_top,
    input logic            mie,
    input logic            busy,
    input logic            stk_err
);
    logic [NIB:0] spf;
    logic         take;
    assign spf  = {sp_top, sp_lo};
    assign take = step && !busy;

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == OP_SEQ) |=> pc == $past(pc) + 1'b1);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !busy) |=> ($stable(pc) && $stable(spf)));

    // R14
    busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R11
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == OP_EI) |=> mie);

    // R9
    int_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == OP_INT && !(&spf)) |=> !mie);

    // R13
    err_keeps_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |-> spf == $past(spf));
endmodule

bind pc_callstack_unit pcs_checker #(.PC_W(PC_W), .NIB(NIB)) u_chk (
    .clk(clk), .rst_n(rst_n), .step(step), .op(op), .pc(pc),
    .sp_lo(sp_lo_sfr), .sp_top(sp_hi_sfr[0]), .mie(mie_sfr[0]),
    .busy(busy), .stk_err(stk_err)
);

// File: tb/sim_pc_callstack_unit.sv
module sim_pc_callstack_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [3:0]  op = '0;
    logic [15:0] imm = '0;
    logic [3:0]  acc = '0;
    logic [7:0]  vec = '0;
    logic [15:0] pc;
    logic [3:0]  sp_lo_sfr, sp_hi_sfr, mie_sfr;
    logic        busy, stk_err;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [15:0] m_pc;
    int          m_sp;
    logic        m_mie;
    logic [15:0] m_stk [32];

    always #5 clk = ~clk;

    pc_callstack_unit u0 (
        .clk(clk), .rst_n(rst_n), .step(step), .op(op), .imm(imm),
        .acc(acc), .vec(vec), .pc(pc), .sp_lo_sfr(sp_lo_sfr),
        .sp_hi_sfr(sp_hi_sfr), .mie_sfr(mie_sfr), .busy(busy),
        .stk_err(stk_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5, 4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R10";
            4'd9: return "R9";
            4'd10, 4'd11: return "R11";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [15:0] jump_of(input logic [3:0] o, input logic [15:0] p,
                                            input logic [15:0] im, input logic [3:0] a,
                                            input logic [7:0] v);
        logic [15:0] nx;
        nx = p + 16'd1;
        case (o)
            4'd1, 4'd5: return im;
            4'd2, 4'd6: return {p[15:12], im[11:0]};
            4'd3: return nx + {{8{im[7]}}, im[7:0]};
            4'd4: return nx + {12'd0, a};
            4'd9: return {8'h00, v};
            default: return nx;
        endcase
    endfunction

    task automatic check_state(input string tag);
        chk({tag, " pc"}, {16'd0, pc}, {16'd0, m_pc});
        chk("R12 sp view", {24'd0, sp_hi_sfr, sp_lo_sfr}, {24'd0, 3'b111, 5'(m_sp)});
        chk("R12 mie view", {28'd0, mie_sfr}, {28'd0, 3'b111, m_mie});
    endtask

    task automatic run_op(input logic [3:0] o, input logic [15:0] im,
                          input logic [3:0] a, input logic [7:0] v);
        logic push, pop, bad;
        push = (o == 4'd5 || o == 4'd6 || o == 4'd9);
        pop  = (o == 4'd7 || o == 4'd8);
        bad  = (push && m_sp == 31) || (pop && m_sp == 0);
        @(negedge clk);
        step = 1'b1; op = o; imm = im; acc = a; vec = v;
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;
        chk("R13 stk_err", {31'd0, stk_err}, {31'd0, bad});
        if (!bad) begin
            if (push) begin
                m_stk[m_sp] = (o == 4'd9) ? m_pc : m_pc + 16'd1;
                m_sp++;
            end
            if (pop) begin
                m_sp--;
                chk("R8 busy", {31'd0, busy}, 32'd1);
                @(posedge clk);
                @(negedge clk);
                m_pc = m_stk[m_sp];
                if (o == 4'd8) m_mie = 1'b1;
            end else begin
                m_pc = jump_of(o, m_pc, im, a, v);
                if (o == 4'd9 || o == 4'd11) m_mie = 1'b0;
                if (o == 4'd10) m_mie = 1'b1;
            end
        end else begin
            chk("R13 no busy", {31'd0, busy}, 32'd0);
        end
        check_state(bad ? "R13" : tag_of(o));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_pc = 16'd0; m_sp = 0; m_mie = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pc", {16'd0, pc}, 32'd0);
        chk("R1 sp", {24'd0, sp_hi_sfr, sp_lo_sfr}, {24'd0, 8'hE0});
        chk("R1 mie", {28'd0, mie_sfr}, 32'hE);
        chk("R1 busy/err", {30'd0, busy, stk_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 hold after reset", {16'd0, pc}, 32'd0);

        run_op(4'd0, 16'h0, 4'h0, 8'h0);        // R2 advance
        run_op(4'd13, 16'h0, 4'h0, 8'h0);       // R2 unused code
        run_op(4'd1, 16'h3FF0, 4'h0, 8'h0);     // R3
        run_op(4'd2, 16'hABCD, 4'h0, 8'h0);     // R4 -> 3BCD
        run_op(4'd3, 16'h0080, 4'h0, 8'h0);     // R5 -128
        run_op(4'd3, 16'h007F, 4'h0, 8'h0);     // R5 +127
        run_op(4'd1, 16'hFFF0, 4'h0, 8'h0);
        run_op(4'd3, 16'h007F, 4'h0, 8'h0);     // R5 wrap
        run_op(4'd4, 16'h0, 4'hF, 8'h0);        // R6 max acc
        run_op(4'd4, 16'h0, 4'h0, 8'h0);        // R6 zero acc
        run_op(4'd7, 16'h0, 4'h0, 8'h0);        // R13 underflow
        run_op(4'd8, 16'h0, 4'h0, 8'h0);        // R13 underflow
        run_op(4'd10, 16'h0, 4'h0, 8'h0);       // R11 enable
        run_op(4'd5, 16'h1234, 4'h0, 8'h0);     // R7 long call
        run_op(4'd6, 16'h0567, 4'h0, 8'h0);     // R7 page call
        run_op(4'd9, 16'h0, 4'h0, 8'h2C);       // R9 interrupt
        run_op(4'd8, 16'h0, 4'h0, 8'h0);        // R10
        run_op(4'd11, 16'h0, 4'h0, 8'h0);       // R11 disable
        run_op(4'd7, 16'h0, 4'h0, 8'h0);        // R8
        run_op(4'd7, 16'h0, 4'h0, 8'h0);        // R8

        // R2 idle hold
        repeat (4) @(negedge clk);
        check_state("R2 idle");

        // R14: inputs during busy are ignored
        run_op(4'd5, 16'h4444, 4'h0, 8'h0);
        @(negedge clk);
        step = 1'b1; op = 4'd7;
        @(posedge clk);
        @(negedge clk);
        op = 4'd1; imm = 16'h9999;
        chk("R14 busy", {31'd0, busy}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;
        m_sp--; m_pc = m_stk[m_sp];
        check_state("R14");
        @(negedge clk);
        check_state("R14 after");

        // R13 overflow: fill to 31, then one more push
        for (int i = 0; i < 40; i++) begin
            if (m_sp < 31 || i == 39) run_op(4'd5, 16'(i * 16'h0111), 4'h0, 8'h0);
        end
        run_op(4'd9, 16'h0, 4'h0, 8'h10);
        // R8 LIFO drain
        while (m_sp > 0) run_op(4'd7, 16'h0, 4'h0, 8'h0);
        run_op(4'd7, 16'h0, 4'h0, 8'h0);

        // mixed random
        for (int i = 0; i < 400; i++) begin
            run_op(4'($urandom % 16), 16'($urandom), 4'($urandom), 8'($urandom));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule